// File: doc/BRIEF.md
# Frame Interrupt Arbiter

This block turns a once-per-frame vertical-blank tick into the interrupt lines of a small 8-bit processor. At each tick it looks at the two active-low coin inputs. If both read low, a coin is present. In that case it raises a maskable interrupt (IRQ) and holds it. Otherwise, if the non-maskable interrupt is enabled, it fires a one-cycle NMI pulse.

The processor reaches the block through a write strobe with a small I/O offset and a data byte. Two offsets control the single NMI enable, and they have opposite polarity:
- The "play" register is active low. It also sets a sound-enable flag.
- The "demo" register is active high.

Any nonzero write to either register drops both interrupt lines. This acts as the interrupt acknowledge. The processor core and the video timing that produces the tick sit outside this block.

Top module: `frame_irq_arbiter`

## Requirements
- R1: After reset, irq, nmi and snd_en are low and the NMI enable is clear, so a tick without a coin gives no NMI.
- R2: A tick with coin_n == 2'b00 sets irq in the cycle after the tick. irq then stays high through idle cycles and later ticks until a clearing write.
- R3: A tick with coin_n != 2'b00 while the NMI enable is set drives nmi high for exactly one cycle, the cycle after the tick.
- R4: A tick with coin_n == 2'b00 gives no NMI pulse, even with the NMI enable set.
- R5: A tick with coin_n != 2'b00 while the NMI enable is clear leaves nmi and irq unchanged.
- R6: A write to offset 4'hA sets the NMI enable and snd_en to 1 when wr_data is all zeros, and to 0 otherwise. This is the active-low play register.
- R7: A write to offset 4'hF sets the NMI enable to 1 when any bit of wr_data is set, and to 0 otherwise. It leaves snd_en unchanged. This is the active-high demo register.
- R8: A write to offset 4'hA or 4'hF with any data bit set clears irq and nmi in the next cycle. A write of all zeros to either offset leaves irq as it was.
- R9: Writes to any other offset have no effect on irq, snd_en or the NMI enable.
- R10: When a write and a tick fall in the same cycle, the tick uses the NMI enable held before the write. A clearing write overrides any IRQ or NMI that the tick would raise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle frame tick (vertical blank) |
| coin_n | input | 2 | Coin inputs, active low; a coin is present when both are 0 |
| wr_en | input | 1 | Processor I/O write strobe |
| wr_addr | input | 4 | I/O write offset |
| wr_data | input | 8 | I/O write data |
| irq | output | 1 | Held maskable interrupt request |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse |
| snd_en | output | 1 | Sound enable flag from the play register |

## Verification
The frame tick and an enable-register write can land in the same clock cycle. The bench provokes this by driving frame_tick and wr_en together in one cycle.

Two cases are judged in the cycle after:
- A nonzero demo write arrives together with a coin tick, and together with a no-coin tick. Both irq and nmi must stay low.
- A zero demo write arrives together with a no-coin tick. The NMI must still pulse, because the enable held before the write governs the tick. The disabled enable then shows on the following tick.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  // Decoded view of one processor write to the arbiter
  typedef struct packed {
    logic play_wr;   // write to the active-low enable register
    logic demo_wr;   // write to the active-high enable register
    logic nonzero;   // any data bit set
    logic clear;     // nonzero write to either enable register
  } wr_dec_t;

endpackage

// File: rtl/fia_rst_sync.sv
module fia_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/fia_enable_regs.sv
module fia_enable_regs
  import frame_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PLAY_OFS = 10,
  parameter int unsigned DEMO_OFS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wr_dec_t           dec,
  output logic              nmi_en,
  output logic              snd_en
);

  localparam logic [ADDR_W-1:0] PLAY_A = ADDR_W'(PLAY_OFS);
  localparam logic [ADDR_W-1:0] DEMO_A = ADDR_W'(DEMO_OFS);

  logic nmi_en_q, nmi_en_d;
  logic snd_en_q, snd_en_d;
  logic reg_ce;

  // write decode
  always_comb begin
    dec.play_wr = wr_en && (wr_addr == PLAY_A);
    dec.demo_wr = wr_en && (wr_addr == DEMO_A);
    dec.nonzero = |wr_data;
    dec.clear   = (dec.play_wr || dec.demo_wr) && dec.nonzero;
  end

  assign reg_ce = dec.play_wr || dec.demo_wr;

  // next state
  always_comb begin
    nmi_en_d = nmi_en_q;
    snd_en_d = snd_en_q;
    if (dec.play_wr) begin
      nmi_en_d = !dec.nonzero;
      snd_en_d = !dec.nonzero;
    end else if (dec.demo_wr) begin
      nmi_en_d = dec.nonzero;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_en_q <= 1'b0;
      snd_en_q <= 1'b0;
    end else if (reg_ce) begin
      nmi_en_q <= nmi_en_d;
      snd_en_q <= snd_en_d;
    end
  end

  assign nmi_en = nmi_en_q;
  assign snd_en = snd_en_q;

  AST_PLAY_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PLAY_A) |=> (nmi_en == !$past(|wr_data)) && (snd_en == nmi_en)); // R6
  AST_DEMO_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == DEMO_A) |=> (nmi_en == $past(|wr_data)) && $stable(snd_en)); // R7
  AST_OTHER_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == PLAY_A || wr_addr == DEMO_A)) |=> $stable(nmi_en) && $stable(snd_en)); // R9

endmodule

// File: rtl/fia_line_gen.sv
module fia_line_gen #(
  parameter int unsigned COIN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [COIN_W-1:0] coin_n,
  input  logic              nmi_en,
  input  logic              clear,
  output logic              irq,
  output logic              nmi
);

  logic irq_q, irq_d;
  logic nmi_q, nmi_d;
  logic coin_seen;

  assign coin_seen = (coin_n == '0);

  // next state: coin beats NMI, clear beats both
  always_comb begin
    irq_d = irq_q;
    nmi_d = 1'b0;
    if (frame_tick) begin
      if (coin_seen)   irq_d = 1'b1;
      else if (nmi_en) nmi_d = 1'b1;
    end
    if (clear) begin
      irq_d = 1'b0;
      nmi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      nmi_q <= nmi_d;
    end
  end

  assign irq = irq_q;
  assign nmi = nmi_q;

  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear) |=> irq); // R2
  AST_COIN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && coin_n == '0 && !clear) |=> (irq && !nmi)); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!irq && !nmi)); // R8
  AST_NMI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick || !nmi_en) |=> !nmi); // R5

endmodule

// File: rtl/frame_irq_arbiter.sv
module frame_irq_arbiter
  import frame_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned COIN_W   = 2,
  parameter int unsigned PLAY_OFS = 10,
  parameter int unsigned DEMO_OFS = 15,
  parameter int unsigned RST_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [COIN_W-1:0] coin_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq,
  output logic              nmi,
  output logic              snd_en
);

  logic    rst_s_n;
  wr_dec_t dec;
  logic    nmi_en;

  fia_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  fia_enable_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PLAY_OFS (PLAY_OFS),
    .DEMO_OFS (DEMO_OFS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dec     (dec),
    .nmi_en  (nmi_en),
    .snd_en  (snd_en)
  );

  fia_line_gen #(.COIN_W(COIN_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .frame_tick (frame_tick),
    .coin_n     (coin_n),
    .nmi_en     (nmi_en),
    .clear      (dec.clear),
    .irq        (irq),
    .nmi        (nmi)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s_n |-> (!irq && !nmi && !snd_en)); // R1

endmodule

// File: tb/frame_irq_arbiter_tb.sv
module frame_irq_arbiter_tb;

  logic       clk;
  logic       rst_n;
  logic       frame_tick;
  logic [1:0] coin_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       irq, nmi, snd_en;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  frame_irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .coin_n(coin_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .nmi(nmi), .snd_en(snd_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive one cycle, optionally a tick and/or a write; outputs then reflect it
  task automatic cyc(input bit tk, input logic [1:0] c, input bit we,
                     input logic [3:0] a, input logic [7:0] d);
    frame_tick = tk; coin_n = c; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    frame_tick = 1'b0; wr_en = 1'b0; coin_n = 2'b11;
  endtask

  task automatic tick(input logic [1:0] c);
    cyc(1'b1, c, 1'b0, 4'h0, 8'h00);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b0, 2'b11, 1'b1, a, d);
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 nmi after reset", nmi, 1'b0);
    chk("R1 snd_en after reset", snd_en, 1'b0);
    tick(2'b11);
    chk("R1 enable clear: no nmi", nmi, 1'b0);
    chk("R5 disabled tick: no irq", irq, 1'b0);
  endtask

  task automatic t_demo_reg;
    wr(4'hF, 8'h01);
    chk("R7 demo write keeps snd_en", snd_en, 1'b0);
    tick(2'b11);
    chk("R3 nmi pulse high", nmi, 1'b1);
    idle(1);
    chk("R3 nmi pulse one cycle", nmi, 1'b0);
    wr(4'hF, 8'h80);
    tick(2'b10);
    chk("R7 bit7 counts as nonzero", nmi, 1'b1);
    wr(4'hF, 8'h00);
    tick(2'b11);
    chk("R7 zero write disables", nmi, 1'b0);
  endtask

  task automatic t_play_reg;
    wr(4'hA, 8'h00);
    chk("R6 zero write sets snd_en", snd_en, 1'b1);
    tick(2'b01);
    chk("R6 zero write enables nmi", nmi, 1'b1);
    wr(4'hA, 8'h04);
    chk("R6 nonzero write clears snd_en", snd_en, 1'b0);
    tick(2'b11);
    chk("R6 nonzero write disables nmi", nmi, 1'b0);
    chk("R5 no irq on disabled tick", irq, 1'b0);
  endtask

  task automatic t_coin;
    wr(4'hA, 8'h00);
    tick(2'b00);
    chk("R2 coin raises irq", irq, 1'b1);
    chk("R4 coin suppresses nmi", nmi, 1'b0);
    idle(3);
    chk("R2 irq held while idle", irq, 1'b1);
    tick(2'b11);
    chk("R3 nmi with irq pending", nmi, 1'b1);
    chk("R2 irq held over tick", irq, 1'b1);
    wr(4'hA, 8'h00);
    chk("R8 zero write keeps irq", irq, 1'b1);
    wr(4'hF, 8'h01);
    chk("R8 nonzero write clears irq", irq, 1'b0);
  endtask

  task automatic t_ignored;
    tick(2'b00);
    chk("R2 irq set before ignore test", irq, 1'b1);
    wr(4'hB, 8'hFF);
    wr(4'h0, 8'h00);
    chk("R9 other offset keeps irq", irq, 1'b1);
    chk("R9 other offset keeps snd_en", snd_en, 1'b1);
    tick(2'b11);
    chk("R9 other offset keeps enable", nmi, 1'b1);
  endtask

  task automatic t_same_cycle;
    // irq is high, enable is 1
    cyc(1'b1, 2'b00, 1'b1, 4'hF, 8'h01);
    chk("R10 clear beats coin irq", irq, 1'b0);
    chk("R10 clear: no nmi", nmi, 1'b0);
    cyc(1'b1, 2'b11, 1'b1, 4'hF, 8'h02);
    chk("R10 clear beats nmi", nmi, 1'b0);
    cyc(1'b1, 2'b11, 1'b1, 4'hF, 8'h00);
    chk("R10 tick uses pre-write enable", nmi, 1'b1);
    tick(2'b11);
    chk("R10 new enable on next tick", nmi, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; frame_tick = 1'b0; coin_n = 2'b11;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_demo_reg();
    t_play_reg();
    t_coin();
    t_ignored();
    t_same_cycle();
    idle(2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule